// File: doc/BRIEF.md
# Dual-Clock Decimal Up/Down Counter

This block is one decimal digit (0 to 9) that counts up on the rising edge of one count clock and down on the rising edge of a second, separate count clock. It has no direction select pin. A free-running system clock samples both count clocks through synchronizers and detects their rising edges, so the whole block is synchronous to that one clock. The exception is the master reset, which clears the digit asynchronously.

An active-low parallel load copies a four-bit value into the digit on every system cycle while it is held low. Two active-low terminal-count outputs are combinational, so a chain of digits can use them:
- The carry output is low while the digit is 9 and the count-up clock is low.
- The borrow output is low while the digit is 0 and the count-down clock is low.

If rising edges on both count clocks are detected in the same system cycle, the digit holds its value and a sticky clash flag is raised.

Top module: `bcd_updown_ctr`

## Requirements
- R1: While `rst` is high, `count` is 0 and `clash_err` is 0. The clear takes effect at once, without a `clk` edge.
- R2: With load inactive, a rising edge on `up_clk` alone increments `count` by one. An increment from 9 gives 0.
- R3: With load inactive, a rising edge on `dn_clk` alone decrements `count` by one. A decrement from 0 gives 9.
- R4: While `par_load_n` is 0 and `rst` is 0, `count` takes `par_data` at every `clk` rising edge. Count-clock edges detected during load are discarded, and releasing load does not replay them.
- R5: `carry_n` is 0 exactly when `count` is 9 and `up_clk` is 0. Otherwise it is 1.
- R6: `borrow_n` is 0 exactly when `count` is 0 and `dn_clk` is 0. Otherwise it is 1.
- R7: If rising edges of `up_clk` and `dn_clk` are detected in the same `clk` cycle while load is inactive, `count` holds and `clash_err` becomes 1. `clash_err` then stays 1 until `rst`.
- R8: From a loaded code of 10 to 15, an increment gives 0 and a decrement gives the code minus one. `carry_n` and `borrow_n` stay 1 at these codes.
- R9: `rst` overrides a simultaneous load. When `rst` falls while load is still low, `count` takes `par_data` at the next `clk` edge.
- R10: A count-clock rising edge changes `count` at the third `clk` rising edge after the count clock rises. It does not change `count` at the second. With no detected edge and load inactive, `count` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Asynchronous master reset, active high |
| par_load_n | input | 1 | Parallel load, active low, level sensitive |
| par_data | input | 4 | Value loaded into the digit |
| up_clk | input | 1 | Count-up clock; its rising edge increments |
| dn_clk | input | 1 | Count-down clock; its rising edge decrements |
| count | output | 4 | Current digit value |
| carry_n | output | 1 | Terminal count-up output, active low |
| borrow_n | output | 1 | Terminal count-down output, active low |
| clash_err | output | 1 | Sticky flag for coincident up and down edges |

## Verification
The hardest case to reach from the ports is the clash. It needs rising edges on both count clocks to be detected in the same system cycle, and that only happens after both clocks have been low together, which normal use forbids. The bench holds both count clocks low for several system cycles and then raises them together at one falling edge of `clk`, so that both synchronizers see the edge in the same cycle. It then confirms that a later legal edge still counts and that the flag stays set. The codes 10 to 15 can only be reached through the parallel load, so the bench sweeps every loaded value from 0 to 15 in both directions.

// File: rtl/bcd_updown_ctr.sv
module bcd_updown_ctr #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       par_load_n,
  input  logic [3:0] par_data,
  input  logic       up_clk,
  input  logic       dn_clk,
  output logic [3:0] count,
  output logic       carry_n,
  output logic       borrow_n,
  output logic       clash_err
);
  localparam logic [3:0] TOP = 4'd9;

  logic [SYNC_STAGES:0] up_sh, dn_sh;
  logic up_edge, dn_edge;
  logic [3:0] nxt;

  assign up_edge = up_sh[SYNC_STAGES-1] & ~up_sh[SYNC_STAGES];
  assign dn_edge = dn_sh[SYNC_STAGES-1] & ~dn_sh[SYNC_STAGES];

  always_comb begin
    nxt = count;
    if (up_edge && !dn_edge)
      nxt = (count >= TOP) ? 4'd0 : 4'(count + 4'd1);
    else if (dn_edge && !up_edge)
      nxt = (count == 4'd0) ? TOP : 4'(count - 4'd1);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      up_sh     <= '1;
      dn_sh     <= '1;
      count     <= 4'd0;
      clash_err <= 1'b0;
    end else begin
      up_sh <= {up_sh[SYNC_STAGES-1:0], up_clk};
      dn_sh <= {dn_sh[SYNC_STAGES-1:0], dn_clk};
      if (!par_load_n)
        count <= par_data;
      else begin
        count <= nxt;
        if (up_edge && dn_edge) clash_err <= 1'b1;
      end
    end
  end

  assign carry_n  = ~((count == TOP) & ~up_clk);
  assign borrow_n = ~((count == 4'd0) & ~dn_clk);

  AST_LOAD_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !par_load_n |=> count == $past(par_data)); // R4
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (par_load_n && up_edge && !dn_edge && count >= TOP) |=> count == 4'd0); // R2
  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (par_load_n && dn_edge && !up_edge && count == 4'd0) |=> count == TOP); // R3
  AST_CLASH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (par_load_n && up_edge && dn_edge) |=> ($stable(count) && clash_err)); // R7
  AST_CLASH_STICKY: assert property (@(posedge clk) disable iff (rst)
    clash_err |=> clash_err); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (par_load_n && !up_edge && !dn_edge) |=> $stable(count)); // R10
endmodule

// File: tb/sim_bcd_updown_ctr.sv
module sim_bcd_updown_ctr;
  logic clk = 0, rst = 1, par_load_n = 1, up_clk = 1, dn_clk = 1;
  logic [3:0] par_data = 0;
  logic [3:0] count;
  logic carry_n, borrow_n, clash_err;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bcd_updown_ctr u0 (.clk(clk), .rst(rst), .par_load_n(par_load_n), .par_data(par_data),
    .up_clk(up_clk), .dn_clk(dn_clk), .count(count), .carry_n(carry_n),
    .borrow_n(borrow_n), .clash_err(clash_err));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(int v);
    par_load_n = 0; par_data = 4'(v);
    step(1);
    par_load_n = 1;
    step(1);
  endtask

  function automatic int up_of(int v); return (v >= 9) ? 0 : v + 1; endfunction
  function automatic int dn_of(int v); return (v == 0) ? 9 : v - 1; endfunction

  task automatic pulse_up(int v);
    up_clk = 0; step(4);
    chk("R5 carry while up low", carry_n, (v == 9) ? 0 : 1);
    up_clk = 1; step(2);
    chk("R10 no change at 2nd edge", count, v);
    step(1);
    chk("R2/R8 increment", count, up_of(v));
    step(2);
  endtask

  task automatic pulse_dn(int v);
    dn_clk = 0; step(4);
    chk("R6 borrow while dn low", borrow_n, (v == 0) ? 0 : 1);
    up_clk = 1; step(0);
    dn_clk = 1; step(3);
    chk("R3/R8 decrement", count, dn_of(v));
    step(2);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 reset count", count, 0);
    chk("R1 reset clash", clash_err, 0);
    chk("R5 carry idle", carry_n, 1);
    chk("R6 borrow idle", borrow_n, 1);
    rst = 0; step(2);
    chk("R10 idle hold", count, 0);

    for (int v = 0; v < 16; v++) begin
      load(v);
      chk("R4 load value", count, v);
      chk("R5/R8 carry high with up high", carry_n, 1);
      pulse_up(v);
      load(v);
      pulse_dn(v);
      chk("R7 no clash", clash_err, 0);
    end

    load(0);
    for (int i = 0; i < 10; i++) begin
      pulse_up(i);
    end
    chk("R2 full cycle wraps", count, 0);

    par_load_n = 0; par_data = 4'd3; step(1);
    chk("R4 track 3", count, 3);
    par_data = 4'd7; step(1);
    chk("R4 track 7", count, 7);
    up_clk = 0; step(4); up_clk = 1; step(5);
    chk("R4 edge during load ignored", count, 7);
    par_load_n = 1; step(4);
    chk("R4 no replay after load", count, 7);

    par_load_n = 0; par_data = 4'd6; step(1);
    #1 rst = 1; #1;
    chk("R9 async reset over load", count, 0);
    step(2);
    chk("R9 held in reset", count, 0);
    rst = 0; step(1);
    chk("R9 load after reset", count, 6);
    par_load_n = 1; step(1);

    load(4);
    up_clk = 0; dn_clk = 0; step(4);
    up_clk = 1; dn_clk = 1; step(5);
    chk("R7 clash holds count", count, 4);
    chk("R7 clash flag", clash_err, 1);
    pulse_up(4);
    chk("R7 flag sticky", clash_err, 1);
    rst = 1; step(1);
    chk("R1 reset clears clash", clash_err, 0);
    rst = 0; step(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule